// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands in the execute stage of a five-stage pipeline, where the operand value comes from. It compares the two source register numbers of the instruction now in execute against the destination register numbers and write-enable flags of the two older instructions still in flight. One of them sits in the stage just after execute; the other sits in the stage after memory access. It then emits one 2-bit select per operand.

When a matching older instruction is going to write the register an operand needs, the select points at that instruction's result, so the operand is taken early. If there is no match, the operand comes from the register file. Register number zero always reads as zero, so it is never bypassed. If both older instructions write the same register, the younger one wins, because its value is the newer one.

A parameter adds the two operand multiplexers inside the block. They take the register-file values and the two in-flight results and drive the final operands. With the parameter cleared, each operand output simply passes the register-file value through. The logic is purely combinational: the select and the operand for any set of inputs appear in the same cycle.

Top module: `opfwd_select_unit`

## Requirements
- R1: When neither in-flight stage qualifies for an operand, its select is 2'b00 and the operand output equals the register-file value for that operand.
- R2: When the post-execute stage has its write enable set, a nonzero destination, and that destination equals source A, sel_a is 2'b10 and opnd_a equals the post-execute result.
- R3: The same rule as R2 applies to source B, driving sel_b to 2'b10 and opnd_b to the post-execute result.
- R4: When the post-memory stage has its write enable set, a nonzero destination equal to a source register, and the post-execute stage does not qualify for that operand, the select is 2'b01 and the operand equals the post-memory result.
- R5: When both stages qualify for the same operand, the select is 2'b10 (the younger, post-execute result wins).
- R6: A destination of register 0 never causes bypassing from either stage, even with the write enable set and a source of 0.
- R7: A stage whose write enable is low never causes bypassing, whatever its destination.
- R8: Select code 2'b11 is never produced on either select output.
- R9: The two operands are resolved independently: one source may bypass while the other does not, and both may bypass from the same or from different stages at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number of the instruction in execute |
| ex_src_b | input | 5 | Second source register number of the instruction in execute |
| pex_wr | input | 1 | Write enable of the instruction one stage past execute |
| pex_dst | input | 5 | Destination register of the instruction one stage past execute |
| pmem_wr | input | 1 | Write enable of the instruction one stage past memory access |
| pmem_dst | input | 5 | Destination register of the instruction one stage past memory access |
| rf_val_a | input | 32 | Register-file value read for source A |
| rf_val_b | input | 32 | Register-file value read for source B |
| pex_res | input | 32 | ALU result held one stage past execute |
| pmem_res | input | 32 | Write-back value held one stage past memory access |
| sel_a | output | 2 | Source select for operand A (00 file, 01 post-memory, 10 post-execute) |
| sel_b | output | 2 | Source select for operand B, same encoding |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
The bench targets the overlap case where both stages write the register an operand reads. A design with the priority inverted would hand the ALU the older, stale post-memory value and report 01 instead of 10. It also sends destination 0 with the write enable set and a source of 0; a selector without the zero guard would bypass a value into what must read as zero. Cases with the write enable low but matching destinations check for a selector that ignores the enable. Mixed cases, with one operand matched and the other not, expose logic that shares or swaps the comparisons between A and B.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    localparam int unsigned REG_W   = 5;
    localparam int unsigned N_OPND  = 2;

    typedef enum logic [1:0] {
        SRC_FILE = 2'b00,
        SRC_PMEM = 2'b01,
        SRC_PEX  = 2'b10
    } opnd_src_e;

    typedef struct packed {
        logic             wr;
        logic [REG_W-1:0] dst;
    } producer_t;

    // A producer qualifies when it writes a nonzero register equal to src.
    function automatic logic producer_hits(input producer_t p,
                                           input logic [REG_W-1:0] src);
        return p.wr && (p.dst != '0) && (p.dst == src);
    endfunction

endpackage

// File: rtl/opfwd_match.sv
module opfwd_match
    import opfwd_pkg::*;
(
    input  producer_t        prod,
    input  logic [REG_W-1:0] src,
    output logic             hit
);
    always_comb hit = producer_hits(prod, src);
endmodule

// File: rtl/opfwd_pick.sv
module opfwd_pick
    import opfwd_pkg::*;
(
    input  logic      hit_pex,
    input  logic      hit_pmem,
    output opnd_src_e sel
);
    // Younger result takes precedence over older.
    always_comb begin
        if (hit_pex)       sel = SRC_PEX;
        else if (hit_pmem) sel = SRC_PMEM;
        else               sel = SRC_FILE;
    end
endmodule

// File: rtl/opfwd_opmux.sv
module opfwd_opmux
    import opfwd_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] from_file,
    input  logic [DATA_W-1:0] from_pmem,
    input  logic [DATA_W-1:0] from_pex,
    output logic [DATA_W-1:0] dout
);
    // Unused code 11 falls back to the register-file path.
    always_comb begin
        unique case (sel)
            SRC_PMEM: dout = from_pmem;
            SRC_PEX:  dout = from_pex;
            default:  dout = from_file;
        endcase
    end
endmodule

// File: rtl/opfwd_select_unit.sv
module opfwd_select_unit
    import opfwd_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter bit          WITH_MUX = 1'b1
) (
    input  logic [4:0]        ex_src_a,
    input  logic [4:0]        ex_src_b,
    input  logic              pex_wr,
    input  logic [4:0]        pex_dst,
    input  logic              pmem_wr,
    input  logic [4:0]        pmem_dst,
    input  logic [DATA_W-1:0] rf_val_a,
    input  logic [DATA_W-1:0] rf_val_b,
    input  logic [DATA_W-1:0] pex_res,
    input  logic [DATA_W-1:0] pmem_res,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    producer_t               prod_pex, prod_pmem;
    logic [REG_W-1:0]        src   [N_OPND];
    logic [DATA_W-1:0]       rfv   [N_OPND];
    opnd_src_e               sel   [N_OPND];
    logic [DATA_W-1:0]       opnd  [N_OPND];
    logic [N_OPND-1:0]       hit_pex, hit_pmem;

    always_comb begin
        prod_pex  = '{wr: pex_wr,  dst: pex_dst};
        prod_pmem = '{wr: pmem_wr, dst: pmem_dst};
        src[0]    = ex_src_a;
        src[1]    = ex_src_b;
        rfv[0]    = rf_val_a;
        rfv[1]    = rf_val_b;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        opfwd_match u_m_pex (.prod(prod_pex),  .src(src[g]), .hit(hit_pex[g]));
        opfwd_match u_m_pmem(.prod(prod_pmem), .src(src[g]), .hit(hit_pmem[g]));
        opfwd_pick  u_pick  (.hit_pex(hit_pex[g]), .hit_pmem(hit_pmem[g]), .sel(sel[g]));

        if (WITH_MUX) begin : g_mux
            opfwd_opmux #(.DATA_W(DATA_W)) u_mux (
                .sel      (sel[g]),
                .from_file(rfv[g]),
                .from_pmem(pmem_res),
                .from_pex (pex_res),
                .dout     (opnd[g])
            );
        end else begin : g_pass
            always_comb opnd[g] = rfv[g];
        end
    end

    always_comb begin
        sel_a  = sel[0];
        sel_b  = sel[1];
        opnd_a = opnd[0];
        opnd_b = opnd[1];
    end
endmodule

// File: rtl/opfwd_select_unit_chk.sv
module opfwd_select_unit_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter bit          WITH_MUX = 1'b1
) (
    input logic [4:0]        ex_src_a,
    input logic [4:0]        ex_src_b,
    input logic              pex_wr,
    input logic [4:0]        pex_dst,
    input logic              pmem_wr,
    input logic [4:0]        pmem_dst,
    input logic [DATA_W-1:0] pex_res,
    input logic [DATA_W-1:0] pmem_res,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);
    always_comb begin
        assert_no_code3_R8: assert (sel_a != 2'b11 && sel_b != 2'b11);
        if (pex_wr && pex_dst != 5'd0 && pex_dst == ex_src_a)
            assert_pex_wins_a_R5: assert (sel_a == 2'b10);
        if (pex_wr && pex_dst != 5'd0 && pex_dst == ex_src_b)
            assert_pex_wins_b_R3: assert (sel_b == 2'b10);
        if (pex_dst == 5'd0 && pmem_dst == 5'd0)
            assert_zero_dst_R6: assert (sel_a == 2'b00 && sel_b == 2'b00);
        if (!pex_wr && !pmem_wr)
            assert_no_wr_R7: assert (sel_a == 2'b00 && sel_b == 2'b00);
        if (WITH_MUX && sel_a == 2'b01)
            assert_pmem_data_R4: assert (opnd_a == pmem_res);
        if (WITH_MUX && sel_b == 2'b10)
            assert_pex_data_R3: assert (opnd_b == pex_res);
    end
endmodule

bind opfwd_select_unit opfwd_select_unit_chk #(.DATA_W(DATA_W), .WITH_MUX(WITH_MUX)) u_chk (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .pex_wr(pex_wr), .pex_dst(pex_dst),
    .pmem_wr(pmem_wr), .pmem_dst(pmem_dst),
    .pex_res(pex_res), .pmem_res(pmem_res),
    .sel_a(sel_a), .sel_b(sel_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
);

// File: tb/test_opfwd_select_unit.sv
module test_opfwd_select_unit;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [4:0]    src_a, src_b, xd, md;
    logic          xw, mw;
    logic [DW-1:0] rfa, rfb, xr, mr;
    logic [1:0]    sa, sb;
    logic [DW-1:0] oa, ob;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    opfwd_select_unit #(.DATA_W(DW), .WITH_MUX(1'b1)) i_opfwd_select_unit (
        .ex_src_a(src_a), .ex_src_b(src_b),
        .pex_wr(xw), .pex_dst(xd), .pmem_wr(mw), .pmem_dst(md),
        .rf_val_a(rfa), .rf_val_b(rfb), .pex_res(xr), .pmem_res(mr),
        .sel_a(sa), .sel_b(sb), .opnd_a(oa), .opnd_b(ob)
    );

    function automatic logic [1:0] ref_sel(input logic [4:0] s);
        if (xw && xd != 0 && xd == s)      return 2'b10;
        else if (mw && md != 0 && md == s) return 2'b01;
        else                               return 2'b00;
    endfunction

    function automatic logic [DW-1:0] ref_val(input logic [1:0] c, input logic [DW-1:0] rf);
        return (c == 2'b10) ? xr : (c == 2'b01) ? mr : rf;
    endfunction

    task automatic apply(input logic [4:0] a, input logic [4:0] b,
                         input logic w1, input logic [4:0] d1,
                         input logic w2, input logic [4:0] d2);
        @(negedge clk);
        src_a = a; src_b = b; xw = w1; xd = d1; mw = w2; md = d2;
        rfa = $urandom; rfb = $urandom; xr = $urandom; mr = $urandom;
        #1;
    endtask

    task automatic check(input string req);
        logic [1:0] ea, eb;
        ea = ref_sel(src_a);
        eb = ref_sel(src_b);
        n_cmp++;
        if (sa !== ea || sb !== eb) begin
            n_bad++;
            $display("FAIL %s sel a/b actual %b/%b expected %b/%b", req, sa, sb, ea, eb);
        end
        n_cmp++;
        if (oa !== ref_val(ea, rfa) || ob !== ref_val(eb, rfb)) begin
            n_bad++;
            $display("FAIL %s opnd a/b actual %h/%h expected %h/%h",
                     req, oa, ob, ref_val(ea, rfa), ref_val(eb, rfb));
        end
    endtask

    task automatic expect_sel(input string req, input logic [1:0] ea, input logic [1:0] eb);
        n_cmp++;
        if (sa !== ea || sb !== eb) begin
            n_bad++;
            $display("FAIL %s directed sel actual %b/%b expected %b/%b", req, sa, sb, ea, eb);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        src_a = 0; src_b = 0; xw = 0; xd = 0; mw = 0; md = 0;
        rfa = 0; rfb = 0; xr = 0; mr = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // R1: idle inputs
        apply(5'd3, 5'd4, 1'b0, 5'd0, 1'b0, 5'd0); expect_sel("R1", 2'b00, 2'b00); check("R1");
        // R2: post-execute match on A only
        apply(5'd7, 5'd9, 1'b1, 5'd7, 1'b0, 5'd0); expect_sel("R2", 2'b10, 2'b00); check("R2");
        // R3: post-execute match on B only
        apply(5'd7, 5'd9, 1'b1, 5'd9, 1'b0, 5'd0); expect_sel("R3", 2'b00, 2'b10); check("R3");
        // R4: post-memory match on both
        apply(5'd12, 5'd12, 1'b0, 5'd12, 1'b1, 5'd12); expect_sel("R4", 2'b01, 2'b01); check("R4");
        // R5: both stages write the same register
        apply(5'd5, 5'd6, 1'b1, 5'd5, 1'b1, 5'd5); expect_sel("R5", 2'b10, 2'b00); check("R5");
        apply(5'd6, 5'd5, 1'b1, 5'd5, 1'b1, 5'd5); expect_sel("R5", 2'b00, 2'b10); check("R5");
        // R6: register zero never bypassed
        apply(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0); expect_sel("R6", 2'b00, 2'b00); check("R6");
        // R7: write enable low with matching destinations
        apply(5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8); expect_sel("R7", 2'b00, 2'b00); check("R7");
        apply(5'd8, 5'd2, 1'b0, 5'd8, 1'b1, 5'd8); expect_sel("R7", 2'b01, 2'b00); check("R7");
        // R9: A from post-execute, B from post-memory
        apply(5'd30, 5'd31, 1'b1, 5'd30, 1'b1, 5'd31); expect_sel("R9", 2'b10, 2'b01); check("R9");
        apply(5'd31, 5'd30, 1'b1, 5'd30, 1'b1, 5'd31); expect_sel("R9", 2'b01, 2'b10); check("R9");

        // Random mix, small register range to force overlaps (R1..R9)
        for (int i = 0; i < 3000; i++) begin
            apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  1'($urandom), 5'($urandom_range(0, 3)),
                  1'($urandom), 5'($urandom_range(0, 3)));
            check("R9");
            n_cmp++;
            if (sa == 2'b11 || sb == 2'b11) begin
                n_bad++;
                $display("FAIL R8 actual %b/%b expected not 11", sa, sb);
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule